// File: doc/BRIEF.md
# Peak-Tracking Negative Slope Detector

This block finds the end of a fast charge on nickel-chemistry cells. The charge current is paused at regular intervals and the battery voltage, turned into a pulse train by a voltage-to-frequency converter, is sampled. The block counts those pulses inside each convert window. It compares every finished count against the highest count seen so far, which is a peak that can only ratchet upward. When the voltage has fallen clearly below that peak on consecutive samples, the block reports a minus-delta-V event and latches a full-charge flag. The charger uses that flag to drop to trickle current.

A timing unit outside the block supplies the preset and convert windows and a flag marking the end of the startup holdoff period. A separate voltage monitor supplies a flag that says whether the sensed voltage lies inside its valid range. A drop pattern seen during holdoff is held and acts once holdoff ends, unless the voltage first climbs back above the peak. Whenever the sensed voltage leaves its valid range, all detector state is cleared.

Top module: `nslope_detect`

## Requirements
- R1: The sample counter is cleared while `preset_i` is high. It then adds one at each clock edge where both `pulse_i` and `convert_i` are high. A pulse that arrives while `convert_i` is low is not counted.
- R2: The sample counter saturates at 2^CNT_W-1 and does not wrap. A saturated count is compared and stored as that maximum value.
- R3: A sample is evaluated at the first clock edge where `convert_i` is low after being high. If the sample is greater than the stored peak, it becomes the new peak. It also clears both the consecutive-drop tally and any pending armed state. The peak never decreases except when it is cleared.
- R4: A sample is a drop event when sample + DROP <= peak (DROP = 2 by default). A sample that neither rises nor drops clears the consecutive-drop tally but leaves an armed state in place. After a clear the peak is 0.
- R5: When RUNS consecutive drop events (2 by default) have occurred and the detector was not already armed, it becomes armed. `dv_pulse_o` is then high for exactly one clock, in the cycle after the evaluating edge.
- R6: `full_o` is set at the clock edge after one where the detector is armed and `holdoff_done_i` is high. Once set, it stays set, even after later rising samples, until a clear.
- R7: An armed state reached while `holdoff_done_i` is low persists across further samples. `full_o` then sets once `holdoff_done_i` goes high, unless a rising sample cancels the armed state first.
- R8: While `window_ok_i` is low, the counter, peak, drop tally, armed state, `full_o` and `dv_pulse_o` are all cleared, and no sample is evaluated. `rst` has the same effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | 1 | One-cycle strobe per converter output pulse |
| preset_i | input | 1 | Preset window: clears the sample counter |
| convert_i | input | 1 | Convert window: pulses are counted while high |
| holdoff_done_i | input | 1 | High once the startup holdoff period has elapsed |
| window_ok_i | input | 1 | High while the sensed voltage is inside its valid range |
| dv_pulse_o | output | 1 | One-cycle pulse when the detector becomes armed |
| full_o | output | 1 | Latched full-charge flag |

## Verification
The bench builds the block with CNT_W = 6, DROP = 2 and RUNS = 2. With a 63-count ceiling, saturation can be reached inside a convert window of under a hundred cycles. This makes the wrap-versus-clamp difference visible through the drop decision that follows. Directed sequences cover stray pulses outside convert, and flat samples breaking a drop run. They also cover a drop pattern held through holdoff and then cancelled or released, and the low-peak corner where no sample can count as a drop. Random counts near the running peak, with random holdoff and window loss, are then checked against a bench model of the peak, tally and armed state.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
  typedef enum logic [1:0] {
    SMP_FLAT = 2'd0,
    SMP_RISE = 2'd1,
    SMP_DROP = 2'd2
  } smp_kind_e;
endpackage

// File: rtl/nsd_pulse_counter.sv
module nsd_pulse_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             cnt_en_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt_o <= '0;
    else if (cnt_en_i && (cnt_o != CNT_MAX))
      cnt_o <= cnt_o + 1'b1;
  end

  // R2: a saturated count stays put until cleared
  p_cnt_clamp_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && !clr_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));

  // R1: without an enabled strobe the count does not move
  p_cnt_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!rst && !clr_i && !cnt_en_i) |=> $stable(cnt_o));

  // R1: preset leaves an empty counter
  p_cnt_clear_r1: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/nsd_peak_reg.sv
module nsd_peak_reg
  import nsd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DROP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             eval_i,
  input  logic [CNT_W-1:0] sample_i,
  output smp_kind_e        kind_o
);
  localparam int EXT_W = CNT_W + $clog2(DROP + 1) + 1;

  logic [CNT_W-1:0] peak_q;
  logic [EXT_W-1:0] lowered;
  logic [EXT_W-1:0] peak_ext;

  assign lowered  = EXT_W'(sample_i) + EXT_W'(DROP);
  assign peak_ext = EXT_W'(peak_q);

  always_comb begin
    if (sample_i > peak_q)
      kind_o = SMP_RISE;
    else if (lowered <= peak_ext)
      kind_o = SMP_DROP;
    else
      kind_o = SMP_FLAT;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      peak_q <= '0;
    else if (eval_i && (kind_o == SMP_RISE))
      peak_q <= sample_i;
  end

  // R3: the peak only ratchets upward between clears
  p_peak_ratchet_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && !clr_i) |=> (peak_q >= $past(peak_q)));

  // R3: an evaluated rise is taken over as the new peak
  p_peak_take_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && eval_i && kind_o == SMP_RISE) |=> (peak_q == $past(sample_i)));
endmodule

// File: rtl/nsd_drop_tracker.sv
module nsd_drop_tracker
  import nsd_pkg::*;
#(
  parameter int RUNS = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr_i,
  input  logic      eval_i,
  input  smp_kind_e kind_i,
  input  logic      holdoff_i,
  output logic      dv_pulse_o,
  output logic      full_o
);
  localparam int RUN_W = $clog2(RUNS + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUNS - 1);
  localparam logic [RUN_W-1:0] RUN_TOP  = RUN_W'(RUNS);

  logic [RUN_W-1:0] streak_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      streak_q   <= '0;
      armed_q    <= 1'b0;
      dv_pulse_o <= 1'b0;
      full_o     <= 1'b0;
    end else begin
      dv_pulse_o <= 1'b0;
      full_o     <= full_o | (armed_q & holdoff_i);
      if (eval_i) begin
        case (kind_i)
          SMP_RISE: begin
            streak_q <= '0;
            armed_q  <= 1'b0;
          end
          SMP_DROP: begin
            if (streak_q >= RUN_LAST) begin
              streak_q <= RUN_TOP;
              if (!armed_q) begin
                armed_q    <= 1'b1;
                dv_pulse_o <= 1'b1;
              end
            end else begin
              streak_q <= streak_q + 1'b1;
            end
          end
          default: streak_q <= '0;
        endcase
      end
    end
  end

  // R5: the event strobe never lasts beyond one cycle
  p_dv_single_r5: assert property (@(posedge clk) disable iff (rst)
    dv_pulse_o |=> !dv_pulse_o);

  // R6: the full flag is sticky while the window stays valid
  p_full_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (full_o && !clr_i) |=> full_o);

  // R7: the full flag only rises after holdoff has ended
  p_full_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(full_o) |-> $past(holdoff_i));

  // R8: a window loss empties the outputs
  p_clear_out_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!full_o && !dv_pulse_o));
endmodule

// File: rtl/nslope_detect.sv
module nslope_detect
  import nsd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DROP  = 2,
  parameter int RUNS  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  input  logic preset_i,
  input  logic convert_i,
  input  logic holdoff_done_i,
  input  logic window_ok_i,
  output logic dv_pulse_o,
  output logic full_o
);
  logic             convert_d;
  logic             eval;
  logic             win_clr;
  logic [CNT_W-1:0] count;
  smp_kind_e        kind;

  assign win_clr = !window_ok_i;
  assign eval    = convert_d && !convert_i && window_ok_i;

  always_ff @(posedge clk) begin
    if (rst) convert_d <= 1'b0;
    else     convert_d <= convert_i;
  end

  nsd_pulse_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (preset_i || win_clr),
    .cnt_en_i (pulse_i && convert_i),
    .cnt_o    (count)
  );

  nsd_peak_reg #(.CNT_W(CNT_W), .DROP(DROP)) u_peak (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (win_clr),
    .eval_i   (eval),
    .sample_i (count),
    .kind_o   (kind)
  );

  nsd_drop_tracker #(.RUNS(RUNS)) u_track (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (win_clr),
    .eval_i     (eval),
    .kind_i     (kind),
    .holdoff_i  (holdoff_done_i),
    .dv_pulse_o (dv_pulse_o),
    .full_o     (full_o)
  );
endmodule

// File: tb/nslope_detect_tb_top.sv
`timescale 1ns/1ps
module nslope_detect_tb_top;
  localparam int CNT_W = 6;
  localparam int DROP  = 2;
  localparam int RUNS  = 2;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_i = 1'b0, preset_i = 1'b0, convert_i = 1'b0;
  logic holdoff_done_i = 1'b0, window_ok_i = 1'b1;
  logic dv_pulse_o, full_o;

  int n_checks = 0;
  int n_fail   = 0;
  int m_peak = 0, m_streak = 0;
  bit m_armed = 0, m_full = 0;

  always #5 clk = ~clk;

  nslope_detect #(.CNT_W(CNT_W), .DROP(DROP), .RUNS(RUNS)) dut_i (
    .clk(clk), .rst(rst), .pulse_i(pulse_i), .preset_i(preset_i),
    .convert_i(convert_i), .holdoff_done_i(holdoff_done_i),
    .window_ok_i(window_ok_i), .dv_pulse_o(dv_pulse_o), .full_o(full_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clamp_cnt(input int n);
    return (n > MAXC) ? MAXC : n;
  endfunction

  // Model step: returns 1 when the detector should newly arm
  function automatic bit model_eval(input int n, input bit hold);
    int s;
    bit fire;
    fire = 0;
    m_full = m_full | (m_armed & hold);
    s = clamp_cnt(n);
    if (s > m_peak) begin
      m_peak = s; m_streak = 0; m_armed = 0;
    end else if (s + DROP <= m_peak) begin
      if (m_streak >= RUNS - 1) begin
        m_streak = RUNS;
        if (!m_armed) begin m_armed = 1; fire = 1; end
      end else m_streak++;
    end else m_streak = 0;
    m_full = m_full | (m_armed & hold);
    return fire;
  endfunction

  // One sample: preset, optional stray pulses, convert window with n pulses
  task automatic sample(input int n, input bit hold, input string req,
                        input int gap = 0, input int sp = 1);
    bit exp_dv;
    int w;
    @(negedge clk);
    holdoff_done_i = hold; preset_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    preset_i = 1'b0;
    for (int g = 0; g < gap; g++) begin
      pulse_i = 1'b1;
      @(negedge clk);
    end
    pulse_i = 1'b0;
    w = n * sp + 2;
    for (int i = 0; i < w; i++) begin
      convert_i = 1'b1;
      pulse_i = ((i % sp) == 0) && ((i / sp) < n);
      @(negedge clk);
    end
    convert_i = 1'b0; pulse_i = 1'b0;
    exp_dv = model_eval(n, hold);
    @(negedge clk);
    check(dv_pulse_o == exp_dv, {req, " dv_pulse"}, dv_pulse_o, exp_dv);
    @(negedge clk);
    check(dv_pulse_o == 1'b0, "R5 dv one cycle", dv_pulse_o, 0);
    check(full_o == m_full, {req, " full"}, full_o, m_full);
  endtask

  task automatic drop_window(input int cyc);
    @(negedge clk);
    window_ok_i = 1'b0;
    for (int i = 0; i < cyc; i++) @(negedge clk);
    window_ok_i = 1'b1;
    m_peak = 0; m_streak = 0; m_armed = 0; m_full = 0;
    @(negedge clk);
    check(full_o == 1'b0, "R8 full cleared", full_o, 0);
    check(dv_pulse_o == 1'b0, "R8 dv cleared", dv_pulse_o, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(full_o == 1'b0, "R8 reset full", full_o, 0);
    check(dv_pulse_o == 1'b0, "R8 reset dv", dv_pulse_o, 0);

    // R4/R5/R6: flat breaks the run; two drops in a row arm and latch
    sample(40, 1, "R3");
    sample(39, 1, "R4 flat");
    sample(38, 1, "R4 drop one");
    sample(39, 1, "R4 flat clears tally");
    sample(38, 1, "R4 drop one again");
    sample(38, 1, "R5 second drop");
    sample(50, 1, "R6 sticky after rise");
    drop_window(2);

    // R7: armed during holdoff, released when holdoff ends
    sample(40, 0, "R7");
    sample(37, 0, "R7 drop");
    sample(37, 0, "R7 armed in holdoff");
    sample(39, 0, "R7 flat keeps armed");
    sample(39, 1, "R7 holdoff ends");
    drop_window(3);

    // R3: rising sample cancels a pending armed state
    sample(40, 0, "R3");
    sample(37, 0, "R3 drop");
    sample(37, 0, "R3 armed");
    sample(45, 0, "R3 rise cancels");
    sample(45, 1, "R3 no latch");
    drop_window(2);

    // R2: saturation then drop relative to the clamped peak
    sample(80, 1, "R2 clamp");
    sample(61, 1, "R2 drop below max");
    sample(61, 1, "R2 second drop");
    drop_window(2);

    // R4: low peak corner, no drop possible
    sample(0, 1, "R4 zero");
    sample(1, 1, "R4 rise to 1");
    sample(0, 1, "R4 not a drop");
    sample(0, 1, "R4 still no drop");
    drop_window(2);

    // R1: stray pulses outside convert, spaced pulses inside
    sample(20, 1, "R1", 0, 2);
    sample(17, 1, "R1 stray ignored", 5, 1);
    sample(17, 1, "R1 stray second drop", 4, 3);
    drop_window(2);

    // Random walk around the running peak
    for (int k = 0; k < 220; k++) begin
      int n;
      bit h;
      if ($urandom_range(0, 24) == 0) drop_window($urandom_range(1, 3));
      if ($urandom_range(0, 15) == 0) n = $urandom_range(0, 75);
      else begin
        n = m_peak + int'($urandom_range(0, 6)) - 4;
        if (n < 0) n = 0;
      end
      h = ($urandom_range(0, 2) != 0);
      sample(n, h, "R4 random", $urandom_range(0, 2), $urandom_range(1, 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule